// File: doc/BRIEF.md
# Sprite Graphics Serializer with Line Delay

This block stores the bitmap for two sprites and turns each 8-bit row into a serial pixel stream, one pixel bit per clock. Each sprite has a direct register that the bus writes, and a delayed register. A write to one sprite's direct register copies the other sprite's direct register into that other sprite's delayed register. Software normally writes the two sprites on alternate lines, so the delayed copy trails the direct copy by exactly one line. A per-sprite select bit picks the direct or the delayed copy. This lets software move a sprite vertically by a single line while it only rewrites graphics every two lines.

A scan starts when the sprite's position counter pulses its trigger. The row is then shifted out most significant bit first, or least significant bit first when the mirror bit is set. A width code stretches each pixel over one, two or four clocks, so the row covers 8, 16 or 32 clocks. A single-bit ball enable has the same direct/delayed pair. Its delayed copy loads on every sprite-1 write, and its own select bit picks which copy drives the ball output.

Top module: `sprite_gfx_shifter`

## Requirements
- R1: Synchronous active-low reset clears both direct registers, both delayed registers, both ball enable copies and any scan in progress; after reset every output is 0.
- R2: A pulse on `wr_p0_i` (or `wr_p1_i`) loads `wr_data_i` into that sprite's direct register at the clock edge.
- R3: A write to one sprite's direct register loads the other sprite's delayed register with the other sprite's direct value from before that edge.
- R4: `wr_ball_i` loads `wr_data_i[1]` into the direct ball enable. A `wr_p1_i` write copies the direct ball enable into the delayed ball enable. `ball_o` shows the delayed copy when `ball_vdel_i` is 1 and the direct copy when it is 0.
- R5: For each sprite, the delay select bit at 1 makes the serializer read the delayed register; at 0 it reads the direct register.
- R6: With the mirror bit at 0 the row leaves as bit 7 first down to bit 0; with it at 1 the row leaves as bit 0 first up to bit 7.
- R7: Width code 2'b00 holds each pixel for 1 clock, 2'b01 for 2 clocks, and 2'b10 or 2'b11 for 4 clocks.
- R8: After the edge that samples a trigger, the first pixel appears in the next cycle and the scan lasts exactly 8 × width clocks; outside a scan the sprite output is 0.
- R9: A trigger that arrives during a scan restarts the scan from its first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_data_i | input | 8 | Bus write data |
| wr_p0_i | input | 1 | Write strobe, sprite 0 direct register |
| wr_p1_i | input | 1 | Write strobe, sprite 1 direct register |
| wr_ball_i | input | 1 | Write strobe, direct ball enable (data bit 1) |
| trig_i | input | 2 | Scan start pulse per sprite from the position counters |
| mirror_i | input | 2 | Per-sprite scan direction, 1 = bit 0 first |
| vdel_i | input | 2 | Per-sprite select, 1 = delayed register |
| width0_i | input | 2 | Sprite 0 pixel width code |
| width1_i | input | 2 | Sprite 1 pixel width code |
| ball_vdel_i | input | 1 | Ball select, 1 = delayed enable |
| pix_o | output | 2 | Serial pixel bit per sprite |
| ball_o | output | 1 | Selected ball enable level |

## Verification
The pixel-hold assertion assumes that the width code does not change while a scan is running. The stimulus therefore sets width, mirror and delay select only while both serializers are idle. Register writes are also made only between scans, so each expected bit comes from a single known row value rather than from a row that changes mid-scan. Trigger pulses last one cycle. The restart case is a deliberate second pulse partway through a scan.

// File: rtl/sprite_gfx_pkg.sv
// Shared constants and helpers for the sprite serializer.
// Assumes a fixed three-step stretch set: 1, 2 or 4 clocks per pixel.
package sprite_gfx_pkg;
    localparam int GFX_W   = 8;
    localparam int WSEL_W  = 2;
    localparam int SUB_W   = 2;
    localparam int BALL_BIT = 1;

    typedef enum logic [WSEL_W-1:0] {
        WID_X1  = 2'b00,
        WID_X2  = 2'b01,
        WID_X4  = 2'b10,
        WID_X4B = 2'b11
    } width_e;

    // Last value of the pixel-hold counter for a width code
    function automatic logic [SUB_W-1:0] hold_last(input logic [WSEL_W-1:0] code);
        case (width_e'(code))
            WID_X1:  hold_last = SUB_W'(0);
            WID_X2:  hold_last = SUB_W'(1);
            default: hold_last = SUB_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/gfx_bank.sv
// Graphics storage: a direct and a delayed row for each of two sprites,
// plus a direct and a delayed ball enable. A write to one sprite's direct
// row copies the other sprite's direct row into its delayed row.
// Assumes write strobes are single-cycle pulses qualified by the bus decode.
module gfx_bank #(
    parameter int W = sprite_gfx_pkg::GFX_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr0_i,
    input  logic                wr1_i,
    input  logic                wr_ball_i,
    input  logic [W-1:0]        data_i,
    input  logic                ball_d_i,
    output logic [1:0][W-1:0]   cur_o,
    output logic [1:0][W-1:0]   dly_o,
    output logic                ball_cur_o,
    output logic                ball_dly_o
);
    logic [1:0][W-1:0] cur_q;
    logic [1:0][W-1:0] dly_q;
    logic              ball_cur_q;
    logic              ball_dly_q;

    // Direct rows take bus data on their own strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            if (wr0_i) cur_q[0] <= data_i;
            if (wr1_i) cur_q[1] <= data_i;
        end
    end

    // Delayed rows copy the partner's direct row on the opposite strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dly_q <= '0;
        end else begin
            if (wr0_i) dly_q[1] <= cur_q[1];
            if (wr1_i) dly_q[0] <= cur_q[0];
        end
    end

    // Ball enable pair: direct on its strobe, delayed on sprite-1 strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ball_cur_q <= 1'b0;
            ball_dly_q <= 1'b0;
        end else begin
            if (wr_ball_i) ball_cur_q <= ball_d_i;
            if (wr1_i)     ball_dly_q <= ball_cur_q;
        end
    end

    assign cur_o      = cur_q;
    assign dly_o      = dly_q;
    assign ball_cur_o = ball_cur_q;
    assign ball_dly_o = ball_dly_q;

    // R2
    direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr0_i |=> cur_q[0] == $past(data_i));

    // R3
    cross_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr0_i |=> dly_q[1] == $past(cur_q[1]));

    // R3
    cross_load_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr1_i |=> dly_q[0] == $past(cur_q[0]));

    // R4
    ball_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr1_i |=> ball_dly_q == $past(ball_cur_q));
endmodule

// File: rtl/gfx_scan.sv
// Parallel-to-serial scanner for one sprite row. A trigger starts (or
// restarts) a scan; each pixel is held for 1, 2 or 4 clocks by width code,
// and the row index walks 0..W-1 mapped to MSB-first or LSB-first order.
// Assumes the width code is held steady while a scan runs.
module gfx_scan
    import sprite_gfx_pkg::*;
#(
    parameter int W = GFX_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WSEL_W-1:0] width_i,
    input  logic              mirror_i,
    input  logic [W-1:0]      row_i,
    output logic              pix_o
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_last;
    logic [IDX_W-1:0] bit_pos;

    // Hold limit for the current width code
    always_comb sub_last = hold_last(width_i);

    // Scan sequencer: restart on trigger, else step hold counter and index
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            sub_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            sub_q    <= '0;
        end else if (active_q) begin
            if (sub_q >= sub_last) begin
                sub_q <= '0;
                if (idx_q == IDX_LAST) active_q <= 1'b0;
                else                   idx_q    <= idx_q + IDX_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end

    // Map scan index to row bit by direction and gate by scan window
    always_comb begin
        bit_pos = mirror_i ? idx_q : (IDX_LAST - idx_q);
        pix_o   = active_q & row_i[bit_pos];
    end

    // R9
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> active_q && idx_q == '0 && sub_q == '0);

    // R8
    scan_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_q) |-> $past(start_i));

    // R7
    pixel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_q && !start_i && sub_q < sub_last) |=> $stable(idx_q));
endmodule

// File: rtl/sprite_gfx_shifter.sv
// Top of the sprite graphics serializer: graphics bank, per-sprite
// direct/delayed selection and one scanner per sprite, plus the ball
// enable selection. Assumes triggers come from the position counters.
module sprite_gfx_shifter
    import sprite_gfx_pkg::*;
#(
    parameter int W = GFX_W
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [7:0]  wr_data_i,
    input  logic        wr_p0_i,
    input  logic        wr_p1_i,
    input  logic        wr_ball_i,
    input  logic [1:0]  trig_i,
    input  logic [1:0]  mirror_i,
    input  logic [1:0]  vdel_i,
    input  logic [1:0]  width0_i,
    input  logic [1:0]  width1_i,
    input  logic        ball_vdel_i,
    output logic [1:0]  pix_o,
    output logic        ball_o
);
    logic [1:0][W-1:0]      cur_rows;
    logic [1:0][W-1:0]      dly_rows;
    logic [1:0][W-1:0]      sel_rows;
    logic [1:0][WSEL_W-1:0] widths;
    logic                   ball_cur;
    logic                   ball_dly;

    gfx_bank #(.W(W)) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr0_i      (wr_p0_i),
        .wr1_i      (wr_p1_i),
        .wr_ball_i  (wr_ball_i),
        .data_i     (wr_data_i[W-1:0]),
        .ball_d_i   (wr_data_i[BALL_BIT]),
        .cur_o      (cur_rows),
        .dly_o      (dly_rows),
        .ball_cur_o (ball_cur),
        .ball_dly_o (ball_dly)
    );

    // Gather per-sprite width codes into an indexable array
    always_comb begin
        widths[0] = width0_i;
        widths[1] = width1_i;
    end

    // Ball output picks the direct or delayed enable
    always_comb ball_o = ball_vdel_i ? ball_dly : ball_cur;

    for (genvar p = 0; p < 2; p++) begin : g_sprite
        // Row source picked by the sprite's delay select
        always_comb sel_rows[p] = vdel_i[p] ? dly_rows[p] : cur_rows[p];

        gfx_scan #(.W(W)) i_scan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .start_i  (trig_i[p]),
            .width_i  (widths[p]),
            .mirror_i (mirror_i[p]),
            .row_i    (sel_rows[p]),
            .pix_o    (pix_o[p])
        );
    end
endmodule

// File: tb/test_sprite_gfx_shifter.sv
module test_sprite_gfx_shifter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_p0 = 1'b0, wr_p1 = 1'b0, wr_ball = 1'b0;
    logic [1:0] trig = '0, mirror = '0, vdel = '0;
    logic [1:0] width0 = '0, width1 = '0;
    logic       ball_vdel = 1'b0;
    logic [1:0] pix;
    logic       ball;

    int n_chk = 0;
    int n_fail = 0;

    sprite_gfx_shifter i_sprite_gfx_shifter (
        .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data),
        .wr_p0_i(wr_p0), .wr_p1_i(wr_p1), .wr_ball_i(wr_ball),
        .trig_i(trig), .mirror_i(mirror), .vdel_i(vdel),
        .width0_i(width0), .width1_i(width1), .ball_vdel_i(ball_vdel),
        .pix_o(pix), .ball_o(ball)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic write_p(input int p, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        if (p == 0) wr_p0 = 1'b1; else wr_p1 = 1'b1;
        @(negedge clk);
        wr_p0 = 1'b0;
        wr_p1 = 1'b0;
    endtask

    task automatic write_ball(input logic en);
        @(negedge clk);
        wr_data = {6'b0, en, 1'b0};
        wr_ball = 1'b1;
        @(negedge clk);
        wr_ball = 1'b0;
    endtask

    function automatic int stretch(input logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    endfunction

    // Trigger sprite p and compare every cycle against the expected stream
    task automatic run_scan(input int p, input int s, input bit mir,
                            input logic [7:0] src, input string req);
        @(negedge clk);
        trig[p] = 1'b1;
        @(negedge clk);
        trig[p] = 1'b0;
        for (int j = 1; j <= 8*s + 2; j++) begin
            logic e;
            int k;
            k = (j - 1) / s;
            if (j <= 8*s) e = mir ? src[k] : src[7-k];
            else          e = 1'b0;
            check(req, pix[p], e);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: load junk, then reset and confirm everything is cleared
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        write_p(0, 8'hFF);
        write_p(1, 8'hFF);
        write_p(0, 8'hFF);
        write_ball(1'b1);
        write_p(1, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 pix0", pix[0], 1'b0);
        check("R1 pix1", pix[1], 1'b0);
        check("R1 ball direct", ball, 1'b0);
        ball_vdel = 1'b1;
        @(negedge clk);
        check("R1 ball delayed", ball, 1'b0);
        ball_vdel = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 2; v++) begin
                vdel[p] = v[0];
                run_scan(p, 1, 1'b0, 8'h00, "R1 cleared row");
            end
        end
        vdel = '0;

        // R2 R3 R5 R6 R7 R8: sweep sprites, widths, mirror, select, patterns
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 4; w++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int v = 0; v < 2; v++) begin
                        for (int n = 0; n < 4; n++) begin
                            logic [7:0] a, b, c;
                            a = 8'h3C ^ 8'(n * 73 + w * 17 + m * 5);
                            b = 8'h99 ^ 8'(n * 29);
                            c = 8'hA5 ^ 8'(n * 37 + v * 11 + p * 3);
                            if (c == a) c = ~a;
                            write_p(p, a);
                            write_p(1 - p, b);
                            write_p(p, c);
                            if (p == 0) width0 = 2'(w); else width1 = 2'(w);
                            mirror[p] = m[0];
                            vdel[p] = v[0];
                            run_scan(p, stretch(2'(w)), m[0], v[0] ? a : c,
                                     v[0] ? "R3 R5 R6 R7 R8 delayed" :
                                            "R2 R5 R6 R7 R8 direct");
                        end
                    end
                end
            end
        end
        vdel = '0; mirror = '0; width0 = '0; width1 = '0;

        // R4: ball direct and delayed copies
        write_ball(1'b1);
        @(negedge clk);
        check("R4 ball direct set", ball, 1'b1);
        ball_vdel = 1'b1;
        @(negedge clk);
        check("R4 ball delayed before copy", ball, 1'b0);
        write_p(1, 8'h00);
        check("R4 ball delayed after p1 write", ball, 1'b1);
        write_ball(1'b0);
        check("R4 ball delayed holds", ball, 1'b1);
        write_p(0, 8'h00);
        check("R4 p0 write leaves delayed ball", ball, 1'b1);
        ball_vdel = 1'b0;
        @(negedge clk);
        check("R4 ball direct cleared", ball, 1'b0);

        // R9: retrigger mid-scan at width x2 restarts from the first pixel
        write_p(0, 8'b1100_1010);
        width0 = 2'b01;
        @(negedge clk);
        trig[0] = 1'b1;
        @(negedge clk);
        trig[0] = 1'b0;
        repeat (5) @(negedge clk);
        run_scan(0, 2, 1'b0, 8'b1100_1010, "R9 restart");

        // R8: no output without a trigger
        for (int j = 0; j < 6; j++) begin
            check("R8 idle", pix[0] | pix[1], 1'b0);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule